// File: doc/BRIEF.md
# Signed-Power-of-Two Shift-Add Multiplier

This block multiplies a 16-bit sign-magnitude data sample by a coefficient that has been encoded ahead of time as a short list of signed power-of-two terms. It is meant to sit in a filter tap where the coefficient set is fixed. The block contains no array multiplier. For each term it shifts the data magnitude right by that term's shift amount and adds the result to a signed accumulator or subtracts it. It spends one clock on each term that is marked present. The accumulator keeps only a few guard bits below the product LSB, so partial-product bits below that point are dropped before they are summed.

When all terms have been processed, the block rounds the accumulator to a 15-bit magnitude by adding half an output LSB and shifting right. It saturates the magnitude at its maximum and attaches a sign. It never produces negative zero.

Operands enter through a valid/ready pair. `in_ready` is high only while the block is idle. A producer holds `in_valid` and its operands until it sees `in_ready` high at a clock edge. While `in_ready` is low, `in_valid` and the operand pins have no effect. The result is reported by a single-cycle `done` pulse, and `prod` stays unchanged until the next result.

Top module: `spt_mult`

## Requirements
- R1: While reset is active and right after it, `in_ready` is 1, `done` is 0 and `prod` is 0.
- R2: An operand pair is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the cycle in which `done` is 1. `in_valid` and the operands are ignored while `in_ready` is 0.
- R3: `in_data` bit 15 is the data sign (1 = negative) and bits 14:0 are the magnitude M. Term i of `in_coef` sits in bits 6i+5:6i. Within a term, bit 5 is present, bit 4 is negative, and bits 3:0 are the shift s. A present term contributes ±floor(M·16 / 2^s) to a signed accumulator.
- R4: Terms whose present bit is 0 contribute nothing. If no term is present, the product is +0 (`prod` = 0x0000).
- R5: With k present terms, `done` is 1 for exactly one cycle. It rises max(k,1)+1 rising edges after the accepting edge.
- R6: The output magnitude is (|A| + 8) >> 4, where A is the final accumulator.
- R7: If that magnitude exceeds 32767, `prod[14:0]` is 32767.
- R8: `prod[15]` equals (A < 0) XOR the data sign, but it is forced to 0 whenever `prod[14:0]` is 0. A zero data magnitude therefore always gives +0.
- R9: `prod` changes only in a cycle where `done` is 1, and it otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on `in_data`/`in_coef` are offered |
| in_ready | output | 1 | Block is idle and takes operands this edge |
| in_data | input | 16 | Sign-magnitude data sample |
| in_coef | input | 18 | Three packed coefficient terms {present, negative, shift[3:0]} |
| done | output | 1 | One-cycle pulse marking a new product |
| prod | output | 16 | Sign-magnitude product, held between pulses |

## Verification
The assertions assume that reset is asserted for at least one edge before operation starts. They also assume that `in_valid` is the only thing the producer uses to signal an offer, so a busy block may see any value on it. The stimulus deliberately keeps `in_valid` high with random operands during busy cycles to show that these are dropped. It offers new operands only with fully known bits, and it draws shifts across the whole 0 to 15 range so that terms truncated to zero, saturating sums and cancelling signs all occur.

// File: rtl/spt_mult_pkg.sv
package spt_mult_pkg;
  localparam int SPT_SHIFT_W = 4;
  localparam int SPT_TERM_W  = SPT_SHIFT_W + 2;

  typedef struct packed {
    logic                   present;
    logic                   negative;
    logic [SPT_SHIFT_W-1:0] shift;
  } spt_term_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } spt_state_t;
endpackage

// File: rtl/spt_shift.sv
module spt_shift #(
  parameter int MAG_W   = 15,
  parameter int GUARD   = 4,
  parameter int SHIFT_W = 4,
  localparam int OUT_W  = MAG_W + GUARD
) (
  input  logic [MAG_W-1:0]   mag,
  input  logic [SHIFT_W-1:0] amount,
  output logic [OUT_W-1:0]   shifted
);
  // logarithmic right shifter over the guard-extended magnitude
  logic [OUT_W-1:0] stage [SHIFT_W+1];

  assign stage[0] = {mag, {GUARD{1'b0}}};

  for (genvar b = 0; b < SHIFT_W; b++) begin : g_stage
    assign stage[b+1] = amount[b] ? (stage[b] >> (1 << b)) : stage[b];
  end

  assign shifted = stage[SHIFT_W];
endmodule

// File: rtl/spt_ctrl.sv
module spt_ctrl
  import spt_mult_pkg::*;
#(
  parameter int TERMS  = 3,
  localparam int IDX_W = (TERMS > 1) ? $clog2(TERMS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [TERMS-1:0] present_mask,
  output logic             idle,
  output logic             step,
  output logic [IDX_W-1:0] step_idx,
  output logic             finish
);
  spt_state_t       state;
  logic [TERMS-1:0] pending;
  logic [TERMS-1:0] lowest;
  logic [TERMS-1:0] remain;

  // lowest pending term goes first
  assign lowest = pending & (~pending + {{(TERMS-1){1'b0}}, 1'b1});
  assign remain = pending & ~lowest;

  always_comb begin
    step_idx = '0;
    for (int i = TERMS - 1; i >= 0; i--) begin
      if (pending[i]) step_idx = IDX_W'(i);
    end
  end

  assign idle   = (state == ST_IDLE);
  assign step   = (state == ST_RUN) && (pending != '0);
  assign finish = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          pending <= present_mask;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          pending <= remain;
          if (remain == '0) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spt_round.sv
module spt_round #(
  parameter int MAG_W  = 15,
  parameter int GUARD  = 4,
  parameter int ACC_W  = 22,
  localparam int SUM_W = ACC_W + 1
) (
  input  logic signed [ACC_W-1:0] acc,
  input  logic                    data_neg,
  output logic [MAG_W:0]          result
);
  localparam logic [SUM_W-1:0] HALF   = SUM_W'(1) << (GUARD - 1);
  localparam logic [SUM_W-1:0] MAXMAG = SUM_W'({MAG_W{1'b1}});

  logic             acc_neg;
  logic [ACC_W-1:0] absval;
  logic [SUM_W-1:0] biased;
  logic [SUM_W-1:0] scaled;
  logic [MAG_W-1:0] mag;
  logic             sign;

  assign acc_neg = acc[ACC_W-1];
  assign absval  = acc_neg ? ACC_W'(-acc) : ACC_W'(acc);
  assign biased  = {1'b0, absval} + HALF;
  assign scaled  = biased >> GUARD;
  assign mag     = (scaled > MAXMAG) ? {MAG_W{1'b1}} : scaled[MAG_W-1:0];
  assign sign    = (acc_neg ^ data_neg) && (mag != '0);
  assign result  = {sign, mag};
endmodule

// File: rtl/spt_mult.sv
module spt_mult
  import spt_mult_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TERMS   = 3,
  parameter int GUARD   = 4,
  localparam int MAG_W  = DATA_W - 1,
  localparam int SH_W   = MAG_W + GUARD,
  localparam int ACC_W  = SH_W + $clog2(TERMS + 1) + 1,
  localparam int COEF_W = TERMS * SPT_TERM_W,
  localparam int IDX_W  = (TERMS > 1) ? $clog2(TERMS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [COEF_W-1:0] in_coef,
  output logic              done,
  output logic [DATA_W-1:0] prod
);
  spt_term_t              coef_in  [TERMS];
  spt_term_t              coef_r   [TERMS];
  logic [TERMS-1:0]       present_mask;
  logic                   accept;
  logic                   step;
  logic                   finish;
  logic [IDX_W-1:0]       step_idx;
  logic [MAG_W-1:0]       data_mag;
  logic                   data_neg;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_next;
  logic [SH_W-1:0]        shifted;
  logic [ACC_W-1:0]       shifted_ext;
  spt_term_t              cur;
  logic [DATA_W-1:0]      rounded;

  for (genvar t = 0; t < TERMS; t++) begin : g_unpack
    assign coef_in[t]      = spt_term_t'(in_coef[t*SPT_TERM_W +: SPT_TERM_W]);
    assign present_mask[t] = coef_in[t].present;
  end

  assign accept = in_valid && in_ready;

  spt_ctrl #(.TERMS(TERMS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .present_mask (present_mask),
    .idle         (in_ready),
    .step         (step),
    .step_idx     (step_idx),
    .finish       (finish)
  );

  assign cur = coef_r[step_idx];

  spt_shift #(.MAG_W(MAG_W), .GUARD(GUARD), .SHIFT_W(SPT_SHIFT_W)) u_shift (
    .mag     (data_mag),
    .amount  (cur.shift),
    .shifted (shifted)
  );

  assign shifted_ext = {{(ACC_W-SH_W){1'b0}}, shifted};
  assign acc_next    = cur.negative ? (acc - $signed(shifted_ext))
                                    : (acc + $signed(shifted_ext));

  spt_round #(.MAG_W(MAG_W), .GUARD(GUARD), .ACC_W(ACC_W)) u_round (
    .acc      (acc),
    .data_neg (data_neg),
    .result   (rounded)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_mag <= '0;
      data_neg <= 1'b0;
      acc      <= '0;
      for (int t = 0; t < TERMS; t++) coef_r[t] <= '0;
    end else if (accept) begin
      data_mag <= in_data[MAG_W-1:0];
      data_neg <= in_data[DATA_W-1];
      acc      <= '0;
      for (int t = 0; t < TERMS; t++) coef_r[t] <= coef_in[t];
    end else if (step) begin
      acc <= acc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      prod <= '0;
    end else begin
      done <= finish;
      if (finish) prod <= rounded;
    end
  end
endmodule

// File: rtl/spt_mult_chk.sv
module spt_mult_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              done,
  input logic [DATA_W-1:0] prod
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  // R9
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(prod));

  // R8
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prod[DATA_W-2:0] == '0) |-> !prod[DATA_W-1]);
endmodule

bind spt_mult spt_mult_chk #(.DATA_W(DATA_W)) u_spt_mult_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .prod     (prod)
);

// File: tb/spt_mult_bench.sv
module spt_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [17:0] in_coef = '0;
  logic        done;
  logic [15:0] prod;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spt_mult u_spt_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_coef(in_coef), .done(done), .prod(prod)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference of one product
  function automatic logic [15:0] ref_prod(logic [15:0] d, logic [17:0] c);
    longint acc = 0;
    longint mag = longint'(d[14:0]);
    longint r;
    logic   s;
    for (int i = 0; i < 3; i++) begin
      logic [5:0] t = c[6*i +: 6];
      if (t[5]) begin
        longint v = (mag * 16) >> t[3:0];
        acc = t[4] ? acc - v : acc + v;
      end
    end
    r = ((acc < 0 ? -acc : acc) + 8) >> 4;
    if (r > 32767) r = 32767;
    s = ((acc < 0) ^ d[15]) && (r != 0);
    return {s, r[14:0]};
  endfunction

  function automatic int ref_lat(logic [17:0] c);
    int k = 0;
    for (int i = 0; i < 3; i++) if (c[6*i+5]) k++;
    return (k < 1 ? 1 : k) + 1;
  endfunction

  // cycle model: countdown to the done pulse
  int          m_cnt = 0;
  logic        m_done = 0;
  logic [15:0] m_prod = '0;
  logic [15:0] m_pend = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_prod = '0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin m_done = 1; m_prod = m_pend; end
      end else if (in_valid) begin
        m_cnt  = ref_lat(in_coef);
        m_pend = ref_prod(in_data, in_coef);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      check("R2 in_ready", 32'(in_ready), 32'(m_cnt == 0));
      check("R5 done", 32'(done), 32'(m_done));
      check("R9 prod", 32'(prod), 32'(m_prod));
    end
    if (cycles > 150000 && !finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [5:0] term(bit p, bit n, int s);
    return {p, n, 4'(s)};
  endfunction

  task automatic run(string tag, logic [15:0] d, logic [17:0] c, bit junk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_coef = c;
    @(negedge clk);
    if (junk) begin
      in_data = 16'($urandom); in_coef = 18'($urandom);
      @(negedge clk);
    end
    in_valid = 0;
    while (!done) @(negedge clk);
    check(tag, 32'(prod), 32'(ref_prod(d, c)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", 32'(in_ready), 32'd1);
    check("R1 done", 32'(done), 32'd0);
    check("R1 prod", 32'(prod), 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", 32'(prod), 32'd0);

    run("R3 single", 16'h0064, {term(0,0,0), term(0,0,0), term(1,0,0)}, 0);
    check("R3 value", 32'(prod), 32'h0064);
    run("R8 negative", 16'h0064, {term(0,0,0), term(0,0,0), term(1,1,0)}, 1);
    check("R8 sign", 32'(prod), 32'h8064);
    run("R4 empty", 16'h8123, 18'h0, 1);
    check("R4 zero", 32'(prod), 32'h0000);
    run("R8 zero data", 16'h8000, {term(1,1,2), term(0,0,0), term(1,0,0)}, 0);
    check("R8 pos zero", 32'(prod), 32'h0000);
    run("R7 saturate", 16'h7fff, {term(1,0,0), term(1,0,0), term(1,0,0)}, 0);
    check("R7 max", 32'(prod), 32'h7fff);
    run("R6 round up", 16'h0003, {term(0,0,0), term(0,0,0), term(1,0,1)}, 0);
    check("R6 half", 32'(prod), 32'h0002);
    run("R3 tiny term", 16'h0001, {term(0,0,0), term(1,0,15), term(0,0,0)}, 0);
    check("R3 truncated", 32'(prod), 32'h0000);
    run("R8 cancel", 16'h8200, {term(1,0,1), term(1,1,0), term(0,0,0)}, 0);
    check("R8 neg data neg coef", 32'(prod), 32'h0100);
    repeat (4) @(negedge clk);
    check("R9 held", 32'(prod), 32'h0100);

    for (int n = 0; n < 400; n++) begin
      logic [17:0] c;
      c = 18'($urandom);
      run("R3 random", 16'($urandom), c, n[0]);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule